// File: doc/BRIEF.md
# Mixed-Width Register Access Bridge

The bridge sits between a bus port and a register file whose registers do not all have the same native width. A bus master may issue byte, word (16-bit) or long (32-bit) accesses. The bridge looks up the native width of the addressed register in a parameter table. It then turns the request into the native accesses the register file can accept, one per clock on a simple native port. The register file answers reads on that port in the same cycle.

There are three cases. A request of the native width becomes a single access. A request narrower than the register becomes one read of the containing register; a write adds a write-back of the merged value. A request wider than the register becomes a run of native-width accesses in ascending address order. In every case the lowest address holds the most significant data. Offsets past the 512-byte window are flagged as errors. Slots marked unimplemented read as zero.

The sequencer has five states:
- IDLE: waits for `bus_start`.
- SPLIT: issues native-width pieces.
- FETCH: reads the containing register.
- MERGE_WR: writes the merged register back.
- REPLY: one cycle that presents the result.

The transitions are:
- accept-reject, IDLE to REPLY: an error offset or an empty slot.
- accept-split, IDLE to SPLIT: the request is as wide as the register or wider.
- accept-narrow, IDLE to FETCH: the request is narrower than the register.
- next-piece, SPLIT to SPLIT.
- last-piece, SPLIT to REPLY.
- fetch-read, FETCH to REPLY.
- fetch-write, FETCH to MERGE_WR.
- writeback, MERGE_WR to REPLY.
- release, REPLY to IDLE.

Top module: `regwidth_bridge`

## Requirements
- R1: After reset `bus_busy`, `bus_done`, `bus_err` and `nat_en` are all low, and `nat_en` is never high while `bus_busy` is low.
- R2: The bus offset is 10 bits. An offset of 0x200 or more completes with `bus_err` high, `bus_rdata` zero, and no native access.
- R3: Each 4-byte slot has a 2-bit code in `WIDTH_MAP`, at bits [2s+1:2s] for slot s = offset[8:2]. The codes are 0 none, 1 byte, 2 word, 3 long. Every native access uses `nat_size` = code-1 (0 byte, 1 word, 2 long). The default map gives slot s the code s mod 4.
- R4: A request whose size equals the slot width makes exactly one native access at the aligned address and returns its data.
- R5: A read narrower than the slot width makes one read of the containing aligned register. It returns the addressed part with the lowest address most significant: at offset 0 of a long, a byte comes from bits 31:24 and a word from bits 31:16.
- R6: A request wider than the slot width makes size/width native accesses at ascending addresses. The first piece carries the most significant bits of the bus data.
- R7: A write narrower than the slot width makes exactly two native accesses to the same address: a read, then a write. The write replaces only the addressed bytes and leaves the other bytes of the register unchanged.
- R8: A request to a slot with code 0 returns zero, makes no native access, and changes no register.
- R9: `bus_busy` rises in the cycle after a start is accepted. `bus_done` is a one-cycle pulse in the cycle after the final native access, after which `bus_busy` is low. A `bus_start` while busy is ignored.
- R10: Bus data is right-justified. `bus_size` is 0 byte, 1 word, 2 long; 3 is treated as long. The offset is aligned down to the request size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_start | input | 1 | Request strobe, taken when idle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Request size code |
| bus_off | input | WIN_BITS+1 | Byte offset |
| bus_wdata | input | 32 | Right-justified write data |
| bus_busy | output | 1 | Request in progress |
| bus_done | output | 1 | Completion pulse |
| bus_err | output | 1 | Out-of-window flag, valid with done |
| bus_rdata | output | 32 | Right-justified read data, valid with done |
| nat_en | output | 1 | Native access strobe |
| nat_we | output | 1 | Native write |
| nat_size | output | 2 | Native size code |
| nat_addr | output | WIN_BITS | Native byte address |
| nat_wdata | output | 32 | Native write data, right-justified |
| nat_rdata | input | 32 | Native read data, same cycle |

## Verification
Every request size is tried against every slot width: byte, word, long and the empty slot. This separates single accesses, big-endian extraction, RMW and splitting by the number and width of native accesses they cause as well as by data.

Misaligned offsets show the alignment rule. Writes with distinct byte patterns, followed by a final comparison of the whole register file, reveal a merge that clobbers neighbouring bytes.

Offsets at and beyond the window edge separate the error path from the empty-slot path. A start raised mid-request shows whether a busy bridge really ignores it.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

    localparam int RWB_DW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_FETCH,
        ST_MERGE_WR,
        ST_REPLY
    } rwb_state_e;

    // right-justified mask of 2**l bytes
    function automatic logic [RWB_DW-1:0] lane_mask(input logic [1:0] l);
        case (l)
            2'd0:    lane_mask = 32'h0000_00FF;
            2'd1:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // default map: slot s carries code s mod 4
    function automatic logic [511:0] cycle_map(input int slots);
        logic [511:0] m;
        m = '0;
        for (int s = 0; s < slots && s < 256; s++) begin
            m[2*s +: 2] = 2'(s);
        end
        return m;
    endfunction

endpackage

// File: rtl/rwb_slot_width.sv
module rwb_slot_width #(
    parameter int SLOTS = 128,
    parameter logic [2*SLOTS-1:0] MAP = '0,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [1:0]        code
);
    logic [1:0] tbl [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign tbl[g] = MAP[2*g +: 2];
    end

    assign code = tbl[slot];
endmodule

// File: rtl/rwb_lane_unit.sv
module rwb_lane_unit
    import rwb_pkg::*;
(
    input  logic [1:0]        sub_l,
    input  logic [1:0]        nat_l,
    input  logic [1:0]        byte_off,
    input  logic [1:0]        piece,
    input  logic [RWB_DW-1:0] cont,
    input  logic [RWB_DW-1:0] wdat,
    output logic [RWB_DW-1:0] ext_data,
    output logic [RWB_DW-1:0] merged_data,
    output logic [RWB_DW-1:0] piece_data
);
    logic [2:0] wb, sb, off_in, nsh;
    logic [3:0] psh;
    logic [RWB_DW-1:0] smask;

    always_comb begin
        wb     = 3'd1 << nat_l;
        sb     = 3'd1 << sub_l;
        off_in = {1'b0, byte_off} & (wb - 3'd1);
        // bytes between the addressed part and the container's low end
        nsh    = wb - off_in - sb;
        // bytes below the current piece in the bus word
        psh    = {1'b0, sb} - ((4'({piece}) + 4'd1) << nat_l);
        smask  = lane_mask(sub_l);
        ext_data    = (cont >> {nsh, 3'b000}) & smask;
        merged_data = (cont & ~(smask << {nsh, 3'b000}))
                    | ((wdat & smask) << {nsh, 3'b000});
        piece_data  = (wdat >> {psh, 3'b000}) & lane_mask(nat_l);
    end
endmodule

// File: rtl/rwb_sequencer.sv
module rwb_sequencer
    import rwb_pkg::*;
#(
    parameter int WIN_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                we,
    input  logic [1:0]          size,
    input  logic [WIN_BITS:0]   off,
    input  logic [RWB_DW-1:0]   wdata,
    input  logic [1:0]          slot_code,
    input  logic [RWB_DW-1:0]   nat_rdata,
    input  logic [RWB_DW-1:0]   ext_data,
    input  logic [RWB_DW-1:0]   merged_data,
    input  logic [RWB_DW-1:0]   piece_data,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [RWB_DW-1:0]   rdata,
    output logic                nat_en,
    output logic                nat_we,
    output logic [1:0]          nat_size,
    output logic [WIN_BITS-1:0] nat_addr,
    output logic [RWB_DW-1:0]   nat_wdata,
    output logic [1:0]          sub_l,
    output logic [1:0]          nat_l,
    output logic [1:0]          piece,
    output logic [WIN_BITS-1:0] addr_q,
    output logic [RWB_DW-1:0]   wdat_q
);
    rwb_state_e state_q, state_d;

    logic              we_q, err_q;
    logic [1:0]        sub_q, nat_q, piece_q, last_q;
    logic [WIN_BITS-1:0] addr_r;
    logic [RWB_DW-1:0] acc_q, wdat_r;

    logic [1:0] req_l, code_l;
    logic       reject, go_split;
    logic [2:0] n_pieces;
    logic [WIN_BITS-1:0] cont_addr;

    always_comb begin
        req_l    = (size == 2'd3) ? 2'd2 : size;
        code_l   = slot_code - 2'd1;
        reject   = off[WIN_BITS] || (slot_code == 2'd0);
        go_split = (req_l >= code_l);
        n_pieces = go_split ? (3'd1 << (req_l - code_l)) : 3'd1;
    end

    assign cont_addr = addr_r & ~WIN_BITS'((3'd1 << nat_q) - 3'd1);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (reject)        state_d = ST_REPLY;
                    else if (go_split) state_d = ST_SPLIT;
                    else               state_d = ST_FETCH;
                end
            end
            ST_SPLIT:    if (piece_q == last_q) state_d = ST_REPLY;
            ST_FETCH:    state_d = we_q ? ST_MERGE_WR : ST_REPLY;
            ST_MERGE_WR: state_d = ST_REPLY;
            ST_REPLY:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request context and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            sub_q   <= 2'd0;
            nat_q   <= 2'd0;
            piece_q <= 2'd0;
            last_q  <= 2'd0;
            addr_r  <= '0;
            acc_q   <= '0;
            wdat_r  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        we_q    <= we;
                        err_q   <= off[WIN_BITS];
                        sub_q   <= req_l;
                        nat_q   <= code_l;
                        piece_q <= 2'd0;
                        last_q  <= 2'(n_pieces - 3'd1);
                        addr_r  <= off[WIN_BITS-1:0]
                                 & ~WIN_BITS'((3'd1 << req_l) - 3'd1);
                        acc_q   <= '0;
                        wdat_r  <= wdata;
                    end
                end
                ST_SPLIT: begin
                    piece_q <= piece_q + 2'd1;
                    if (!we_q)
                        acc_q <= (acc_q << {(3'd1 << nat_q), 3'b000})
                               | (nat_rdata & lane_mask(nat_q));
                end
                ST_FETCH: begin
                    if (we_q) wdat_r <= merged_data;
                    else      acc_q  <= ext_data;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        nat_en    = 1'b0;
        nat_we    = 1'b0;
        nat_size  = nat_q;
        nat_addr  = '0;
        nat_wdata = '0;
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        err       = 1'b0;
        rdata     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SPLIT: begin
                nat_en    = 1'b1;
                nat_we    = we_q;
                nat_addr  = addr_r + (WIN_BITS'(piece_q) << nat_q);
                nat_wdata = we_q ? piece_data : '0;
            end
            ST_FETCH: begin
                nat_en   = 1'b1;
                nat_addr = cont_addr;
            end
            ST_MERGE_WR: begin
                nat_en    = 1'b1;
                nat_we    = 1'b1;
                nat_addr  = cont_addr;
                nat_wdata = wdat_r;
            end
            ST_REPLY: begin
                done  = 1'b1;
                err   = err_q;
                rdata = acc_q;
            end
            default: ;
        endcase
    end

    assign sub_l  = sub_q;
    assign nat_l  = nat_q;
    assign piece  = piece_q;
    assign addr_q = addr_r;
    assign wdat_q = wdat_r;
endmodule

// File: rtl/regwidth_bridge.sv
module regwidth_bridge
    import rwb_pkg::*;
#(
    parameter int WIN_BITS = 9,
    parameter int SLOTS = 1 << (WIN_BITS - 2),
    parameter logic [2*SLOTS-1:0] WIDTH_MAP = (2*SLOTS)'(rwb_pkg::cycle_map(SLOTS))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_start,
    input  logic                bus_we,
    input  logic [1:0]          bus_size,
    input  logic [WIN_BITS:0]   bus_off,
    input  logic [31:0]         bus_wdata,
    output logic                bus_busy,
    output logic                bus_done,
    output logic                bus_err,
    output logic [31:0]         bus_rdata,
    output logic                nat_en,
    output logic                nat_we,
    output logic [1:0]          nat_size,
    output logic [WIN_BITS-1:0] nat_addr,
    output logic [31:0]         nat_wdata,
    input  logic [31:0]         nat_rdata
);
    localparam int SLOT_W = WIN_BITS - 2;

    logic [1:0]          slot_code, sub_l, nat_l, piece;
    logic [WIN_BITS-1:0] addr_q;
    logic [RWB_DW-1:0]   wdat_q, ext_data, merged_data, piece_data;

    rwb_slot_width #(.SLOTS(SLOTS), .MAP(WIDTH_MAP)) lookup_i (
        .slot (bus_off[WIN_BITS-1 -: SLOT_W]),
        .code (slot_code)
    );

    rwb_lane_unit lanes_i (
        .sub_l       (sub_l),
        .nat_l       (nat_l),
        .byte_off    (addr_q[1:0]),
        .piece       (piece),
        .cont        (nat_rdata),
        .wdat        (wdat_q),
        .ext_data    (ext_data),
        .merged_data (merged_data),
        .piece_data  (piece_data)
    );

    rwb_sequencer #(.WIN_BITS(WIN_BITS)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (bus_start),
        .we          (bus_we),
        .size        (bus_size),
        .off         (bus_off),
        .wdata       (bus_wdata),
        .slot_code   (slot_code),
        .nat_rdata   (nat_rdata),
        .ext_data    (ext_data),
        .merged_data (merged_data),
        .piece_data  (piece_data),
        .busy        (bus_busy),
        .done        (bus_done),
        .err         (bus_err),
        .rdata       (bus_rdata),
        .nat_en      (nat_en),
        .nat_we      (nat_we),
        .nat_size    (nat_size),
        .nat_addr    (nat_addr),
        .nat_wdata   (nat_wdata),
        .sub_l       (sub_l),
        .nat_l       (nat_l),
        .piece       (piece),
        .addr_q      (addr_q),
        .wdat_q      (wdat_q)
    );
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
    parameter int WIN_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_start,
    input logic                bus_busy,
    input logic                bus_done,
    input logic                bus_err,
    input logic [31:0]         bus_rdata,
    input logic                nat_en,
    input logic                nat_we,
    input logic [1:0]          nat_size,
    input logic [WIN_BITS-1:0] nat_addr
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> !nat_en);

    p_err_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done && bus_err) |-> ($past(!nat_en) && bus_rdata == 32'd0));

    p_width_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nat_en && $past(nat_en)) |-> $stable(nat_size));

    p_no_size3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nat_en |-> nat_size != 2'd3);

    p_rmw_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nat_en && nat_we && $past(nat_en && !nat_we)) |-> nat_addr == $past(nat_addr));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> (!bus_done && !bus_busy));

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_busy) |=> bus_busy);

    p_done_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |-> !nat_en);
endmodule

bind regwidth_bridge rwb_checker #(.WIN_BITS(WIN_BITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .bus_busy  (bus_busy),
    .bus_done  (bus_done),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .nat_en    (nat_en),
    .nat_we    (nat_we),
    .nat_size  (nat_size),
    .nat_addr  (nat_addr)
);

// File: tb/regwidth_bridge_tb_top.sv
module regwidth_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WB = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_start = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_size = 2'd0;
    logic [WB:0] bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_busy, bus_done, bus_err;
    logic [31:0] bus_rdata;
    logic nat_en, nat_we;
    logic [1:0] nat_size;
    logic [WB-1:0] nat_addr;
    logic [31:0] nat_wdata, nat_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwidth_bridge dut_i (.*);

    int total = 0, bad = 0, cycles = 0;
    bit finished = 1'b0;

    logic [7:0] mem   [512];
    logic [7:0] ref_m [512];

    logic [31:0] q_rd [$];
    logic        q_err [$];
    int          q_cnt [$];
    int          q_w [$];
    string       q_tag [$];
    int          seen = 0;

    // register file stub, big-endian bytes
    always_comb begin
        case (nat_size)
            2'd0:    nat_rdata = {24'd0, mem[nat_addr]};
            2'd1:    nat_rdata = {16'd0, mem[nat_addr], mem[9'(nat_addr + 9'd1)]};
            default: nat_rdata = {mem[nat_addr], mem[9'(nat_addr + 9'd1)],
                                  mem[9'(nat_addr + 9'd2)], mem[9'(nat_addr + 9'd3)]};
        endcase
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: native writes land in the stub, results compared on done
    always @(negedge clk) begin
        if (rst_n && nat_en) begin
            seen++;
            if (q_w.size() > 0)
                check(int'(nat_size) == q_w[0], {q_tag[0], " R3 native width"},
                      32'(nat_size), 32'(q_w[0]));
            else
                check(1'b0, "R9 unexpected native access", 32'(nat_addr), 32'd0);
            if (nat_we) begin
                for (int k = 0; k < (1 << nat_size); k++)
                    mem[9'(nat_addr + 9'(k))] = 8'(nat_wdata >> (8 * ((1 << nat_size) - 1 - k)));
            end
        end
        if (rst_n && bus_done) begin
            if (q_rd.size() == 0) begin
                check(1'b0, "R9 done without request", bus_rdata, 32'd0);
            end else begin
                check(bus_rdata == q_rd[0], {q_tag[0], " rdata"}, bus_rdata, q_rd[0]);
                check(bus_err == q_err[0], {q_tag[0], " R2 err"}, 32'(bus_err), 32'(q_err[0]));
                check(seen == q_cnt[0], {q_tag[0], " access count"}, 32'(seen), 32'(q_cnt[0]));
                void'(q_rd.pop_front()); void'(q_err.pop_front());
                void'(q_cnt.pop_front()); void'(q_w.pop_front()); void'(q_tag.pop_front());
            end
            seen = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "watchdog expired", 32'(cycles), 32'd0);
            summary();
        end
    end

    // driver: computes expectations from the requirements, then issues
    task automatic txn(input bit we, input logic [1:0] sz, input logic [9:0] off,
                       input logic [31:0] wd, input string tag, input bit poke = 1'b0);
        int sl, wl, sb, cnt, code;
        logic [8:0] a;
        logic [31:0] rd;
        sl = (sz == 2'd3) ? 2 : int'(sz);
        sb = 1 << sl;
        code = int'(off[3:2]);
        rd = '0; cnt = 0; wl = 0;
        a = off[8:0] & ~9'(sb - 1);
        if (!off[9] && code != 0) begin
            wl = code - 1;
            cnt = (sl >= wl) ? (1 << (sl - wl)) : (we ? 2 : 1);
            for (int k = 0; k < sb; k++) begin
                if (we) ref_m[9'(a + 9'(k))] = 8'(wd >> (8 * (sb - 1 - k)));
                else    rd = (rd << 8) | 32'(ref_m[9'(a + 9'(k))]);
            end
        end
        q_rd.push_back(rd); q_err.push_back(off[9]); q_cnt.push_back(cnt);
        q_w.push_back(wl); q_tag.push_back(tag);
        @(negedge clk);
        bus_start = 1'b1; bus_we = we; bus_size = sz; bus_off = off; bus_wdata = wd;
        @(negedge clk);
        bus_start = 1'b0;
        if (poke) begin
            bus_start = 1'b1; bus_we = 1'b1; bus_size = 2'd2;
            bus_off = 10'h00C; bus_wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            bus_start = 1'b0;
        end
        while (bus_busy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 37 + 11);
            ref_m[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        check(!bus_busy && !bus_done && !bus_err && !nat_en, "R1 reset state",
              {28'd0, bus_busy, bus_done, bus_err, nat_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_busy && !nat_en, "R1 idle after reset", {30'd0, bus_busy, nat_en}, 32'd0);

        txn(0, 2'd2, 10'h00C, 0, "R4 long of long");
        txn(0, 2'd0, 10'h005, 0, "R4 byte of byte");
        txn(0, 2'd1, 10'h00A, 0, "R4 word of word");
        txn(0, 2'd0, 10'h00C, 0, "R5 byte0 of long");
        txn(0, 2'd0, 10'h00F, 0, "R5 byte3 of long");
        txn(0, 2'd1, 10'h00E, 0, "R5 low word of long");
        txn(0, 2'd0, 10'h008, 0, "R5 even byte of word");
        txn(0, 2'd0, 10'h009, 0, "R5 odd byte of word");
        txn(0, 2'd1, 10'h004, 0, "R6 word of bytes");
        txn(0, 2'd2, 10'h004, 0, "R6 long of bytes");
        txn(0, 2'd2, 10'h008, 0, "R6 long of words");
        txn(0, 2'd1, 10'h00D, 0, "R10 misaligned word");
        txn(0, 2'd3, 10'h01E, 0, "R10 size3 as long");
        txn(1, 2'd0, 10'h00D, 32'hA5, "R7 byte into long");
        txn(1, 2'd1, 10'h02E, 32'hBEEF, "R7 word into long");
        txn(1, 2'd0, 10'h009, 32'h3C, "R7 byte into word");
        txn(0, 2'd2, 10'h00C, 0, "R7 long readback");
        txn(0, 2'd2, 10'h02C, 0, "R7 long readback 2");
        txn(0, 2'd1, 10'h008, 0, "R7 word readback");
        txn(1, 2'd1, 10'h006, 32'h1234, "R6 word write bytes");
        txn(1, 2'd2, 10'h014, 32'hDEAD_BEEF, "R6 long write bytes");
        txn(1, 2'd2, 10'h018, 32'hCAFE_F00D, "R6 long write words");
        txn(1, 2'd2, 10'h01C, 32'h0123_4567, "R4 long write long");
        txn(0, 2'd2, 10'h004, 0, "R6 readback 4");
        txn(0, 2'd2, 10'h014, 0, "R6 readback 14");
        txn(0, 2'd2, 10'h018, 0, "R6 readback 18");
        txn(0, 2'd2, 10'h01C, 0, "R4 readback 1C");
        txn(0, 2'd2, 10'h010, 0, "R8 empty read");
        txn(1, 2'd2, 10'h010, 32'h5555_5555, "R8 empty long write");
        txn(1, 2'd0, 10'h031, 32'h77, "R8 empty byte write");
        txn(0, 2'd1, 10'h012, 0, "R8 empty word read");
        txn(0, 2'd2, 10'h200, 0, "R2 edge of window");
        txn(1, 2'd2, 10'h3FC, 32'h1111_1111, "R2 top write");
        txn(0, 2'd0, 10'h2FF, 0, "R2 byte past window");
        txn(0, 2'd2, 10'h1FC, 0, "R2 last slot in window");
        txn(0, 2'd2, 10'h024, 0, "R9 busy start ignored", 1'b1);
        txn(0, 2'd2, 10'h00C, 0, "R9 register untouched by ignored start");

        repeat (3) @(negedge clk);
        check(q_rd.size() == 0, "R9 all requests completed", 32'(q_rd.size()), 32'd0);
        begin
            int diffs = 0;
            for (int i = 0; i < 512; i++)
                if (mem[i] != ref_m[i]) diffs++;
            check(diffs == 0, "R7 R8 register file contents", 32'(diffs), 32'd0);
        end
        summary();
    end
endmodule